// File: doc/BRIEF.md
# Three-Channel Temperature Monitor Register Block

This block holds the registers of a small temperature monitor with three sensor channels. The converter front end passes it one signed Celsius reading per channel, each with a strobe and an open-circuit flag. The block keeps each channel's latest reading and compares it against three signed limits of its own. When a limit is crossed it raises a sticky warning flag. An over-temperature flag on any channel drives a single alarm output. The output stays asserted until software clears every over-temperature flag.

The host reaches the block through a 16-byte window with a flat address, a write strobe and a combinational read port. A global standby bit stops conversion, so incoming readings are discarded while it is set. A channel-select register decides which channel's bank (status, reading and the three limits) appears at the shared bank offsets. Warning flags clear only when a 1 is written to them. A clear that meets a still-true condition in the same cycle loses to the condition.

Top module: `thermal_monitor_regs`

## Requirements
- R1: After reset, offset 0x08 and offset 0x09 read 0. In every bank the status reads 0x00 and the reading reads 0x00. The high limit and the over-temperature limit read 0x7F, the low limit reads 0x80, and `overTempOut` is 0.
- R2: Offset 0x09 holds the channel index (0 to 2) that chooses the bank shown at offsets 0x0A to 0x0E. A write of a value of 3 or more is ignored, and the index reads back zero-extended.
- R3: Bit 0 of offset 0x08 is a read/write standby bit. While it is 1, every sample is discarded: no reading, open flag or warning flag changes.
- R4: Bit 0 of the status byte (offset 0x0A) is a read/write channel enable. A sample presented to a disabled channel changes nothing.
- R5: A sample presented to an enabled channel, with no open-circuit flag and standby off, appears as a two's-complement byte at offset 0x0B after the next clock edge.
- R6: Each accepted sample is compared signed against the channel's limits. Status bit 1 sets when reading <= low limit (offset 0x0D). Bit 2 sets when reading >= high limit (offset 0x0C). Bit 3 sets when reading >= over-temperature limit (offset 0x0E). A later in-range sample does not clear a set flag.
- R7: Writing 1 to status bits 1, 2 or 3 clears that flag, and writing 0 leaves it unchanged. Bit 6 and bits 4, 5 and 7 ignore writes, and bits 4, 5 and 7 read 0.
- R8: If a clear write and an accepted sample that meets the same flag's condition land in the same cycle, the flag stays set. If the sample does not meet the condition, the clear wins.
- R9: A sample on an enabled channel that carries the open-circuit flag sets status bit 6. It leaves the reading and the warning flags untouched. The next accepted sample without the flag clears bit 6.
- R10: `overTempOut` is 1 exactly when status bit 3 of at least one channel is 1, and it drops in the cycle after the last such bit is cleared.
- R11: Offsets 0x00 to 0x07 and 0x0F read 0 and ignore writes. Bits 7:1 of offset 0x08 read 0.
- R12: The three limit registers are read/write, and each channel has its own independent copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register offset in the 16-byte window |
| wrEn | input | 1 | Write strobe for `wrData` at `regAddr` |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `regAddr` |
| sampleValid | input | 3 | One strobe per channel: a new reading is present |
| sampleTemp | input | 24 | Signed readings, channel n in bits 8n+7:8n |
| sampleOpen | input | 3 | Open-circuit indication per channel, qualified by `sampleValid` |
| overTempOut | output | 1 | Over-temperature alarm |

## Verification
The host's write-1 clear of a warning flag and a fresh sample's comparison can land on the same flag in the same clock cycle. The bench provokes this by raising the status write strobe and the channel's sample strobe on the same falling edge. It does so once with a reading that still exceeds the limits and once with a reading back in range. It then expects the flags to stay set in the first case and to clear in the second. The bench also sweeps all 256 reading values against a fixed limit set and derives each expected flag pattern with signed arithmetic.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_STANDBY = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_SELECT  = 4'h9;
  localparam logic [ADDR_W-1:0] OFF_STATUS  = 4'hA;
  localparam logic [ADDR_W-1:0] OFF_READING = 4'hB;
  localparam logic [ADDR_W-1:0] OFF_HIGH    = 4'hC;
  localparam logic [ADDR_W-1:0] OFF_LOW     = 4'hD;
  localparam logic [ADDR_W-1:0] OFF_CRIT    = 4'hE;

  // status byte field positions
  localparam int ST_EN   = 0;
  localparam int ST_LOW  = 1;
  localparam int ST_HIGH = 2;
  localparam int ST_CRIT = 3;
  localparam int ST_OPEN = 6;

  typedef struct packed {
    logic wrStandby;
    logic wrSelect;
    logic wrStatus;
    logic wrHigh;
    logic wrLow;
    logic wrCrit;
  } tmonStrobes_t;
endpackage

// File: rtl/tmon_ctrl.sv
module tmon_ctrl
  import tmon_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int SEL_W  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output tmonStrobes_t        strobes,
  output logic                standbyQ,
  output logic [SEL_W-1:0]    chanSel
);
  always_comb begin
    strobes.wrStandby = wrEn && (regAddr == OFF_STANDBY);
    strobes.wrSelect  = wrEn && (regAddr == OFF_SELECT);
    strobes.wrStatus  = wrEn && (regAddr == OFF_STATUS);
    strobes.wrHigh    = wrEn && (regAddr == OFF_HIGH);
    strobes.wrLow     = wrEn && (regAddr == OFF_LOW);
    strobes.wrCrit    = wrEn && (regAddr == OFF_CRIT);
  end

  logic selLegal;
  assign selLegal = (32'(wrData) < NUM_CH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      standbyQ <= 1'b0;
      chanSel  <= '0;
    end else begin
      if (strobes.wrStandby) standbyQ <= wrData[0];
      if (strobes.wrSelect && selLegal) chanSel <= wrData[SEL_W-1:0];
    end
  end
endmodule

// File: rtl/tmon_datapath.sv
module tmon_datapath
  import tmon_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int SEL_W  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tmonStrobes_t               strobes,
  input  logic                       standbyQ,
  input  logic [SEL_W-1:0]           chanSel,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [NUM_CH-1:0]          sampleValid,
  input  logic [NUM_CH*DATA_W-1:0]   sampleTemp,
  input  logic [NUM_CH-1:0]          sampleOpen,
  output logic [DATA_W-1:0]          bankData,
  output logic [NUM_CH-1:0]          critFlags
);
  logic [DATA_W-1:0] statusArr  [NUM_CH];
  logic [DATA_W-1:0] readingArr [NUM_CH];
  logic [DATA_W-1:0] highArr    [NUM_CH];
  logic [DATA_W-1:0] lowArr     [NUM_CH];
  logic [DATA_W-1:0] critArr    [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic enQ, lowQ, highQ, critQ, openQ;
    logic signed [DATA_W-1:0] readingQ, highLim, lowLim, critLim;
    logic signed [DATA_W-1:0] newTemp;
    logic selHit, accept, good, clrHit;

    assign newTemp = $signed(sampleTemp[ch*DATA_W +: DATA_W]);
    assign selHit  = (32'(chanSel) == ch);
    assign accept  = sampleValid[ch] && enQ && !standbyQ;
    assign good    = accept && !sampleOpen[ch];
    assign clrHit  = strobes.wrStatus && selHit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ      <= 1'b0;
        lowQ     <= 1'b0;
        highQ    <= 1'b0;
        critQ    <= 1'b0;
        openQ    <= 1'b0;
        readingQ <= '0;
        highLim  <= 8'sh7F;
        lowLim   <= 8'sh80;
        critLim  <= 8'sh7F;
      end else begin
        if (clrHit) enQ <= wrData[ST_EN];
        lowQ  <= (good && (newTemp <= lowLim))
               || (lowQ && !(clrHit && wrData[ST_LOW]));
        highQ <= (good && (newTemp >= highLim))
               || (highQ && !(clrHit && wrData[ST_HIGH]));
        critQ <= (good && (newTemp >= critLim))
               || (critQ && !(clrHit && wrData[ST_CRIT]));
        if (accept) openQ <= sampleOpen[ch];
        if (good) readingQ <= newTemp;
        if (strobes.wrHigh && selHit) highLim <= $signed(wrData);
        if (strobes.wrLow  && selHit) lowLim  <= $signed(wrData);
        if (strobes.wrCrit && selHit) critLim <= $signed(wrData);
      end
    end

    always_comb begin
      statusArr[ch]          = '0;
      statusArr[ch][ST_EN]   = enQ;
      statusArr[ch][ST_LOW]  = lowQ;
      statusArr[ch][ST_HIGH] = highQ;
      statusArr[ch][ST_CRIT] = critQ;
      statusArr[ch][ST_OPEN] = openQ;
    end
    assign readingArr[ch] = readingQ;
    assign highArr[ch]    = highLim;
    assign lowArr[ch]     = lowLim;
    assign critArr[ch]    = critLim;
    assign critFlags[ch]  = critQ;
  end

  always_comb begin
    unique case (regAddr)
      OFF_STATUS:  bankData = statusArr[chanSel];
      OFF_READING: bankData = readingArr[chanSel];
      OFF_HIGH:    bankData = highArr[chanSel];
      OFF_LOW:     bankData = lowArr[chanSel];
      OFF_CRIT:    bankData = critArr[chanSel];
      default:     bankData = '0;
    endcase
  end
endmodule

// File: rtl/thermal_monitor_regs.sv
module thermal_monitor_regs
  import tmon_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic                     wrEn,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  input  logic [NUM_CH-1:0]        sampleValid,
  input  logic [NUM_CH*DATA_W-1:0] sampleTemp,
  input  logic [NUM_CH-1:0]        sampleOpen,
  output logic                     overTempOut
);
  tmonStrobes_t      strobes;
  logic              standbyQ;
  logic [SEL_W-1:0]  chanSel;
  logic [DATA_W-1:0] bankData;
  logic [NUM_CH-1:0] critFlags;

  tmon_ctrl #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .strobes(strobes), .standbyQ(standbyQ), .chanSel(chanSel)
  );

  tmon_datapath #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .standbyQ(standbyQ),
    .chanSel(chanSel), .regAddr(regAddr), .wrData(wrData),
    .sampleValid(sampleValid), .sampleTemp(sampleTemp), .sampleOpen(sampleOpen),
    .bankData(bankData), .critFlags(critFlags)
  );

  always_comb begin
    unique case (regAddr)
      OFF_STANDBY: rdData = {{(DATA_W-1){1'b0}}, standbyQ};
      OFF_SELECT:  rdData = {{(DATA_W-SEL_W){1'b0}}, chanSel};
      OFF_STATUS, OFF_READING, OFF_HIGH, OFF_LOW, OFF_CRIT: rdData = bankData;
      default:     rdData = '0;
    endcase
  end

  assign overTempOut = |critFlags;
endmodule

// File: rtl/tmon_checker.sv
module tmon_checker
  import tmon_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int SEL_W  = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               wrEn,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic [NUM_CH-1:0]  sampleValid,
  input logic               overTempOut,
  input logic               standbyQ,
  input logic [SEL_W-1:0]   chanSel
);
  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    32'(chanSel) < NUM_CH); // R2

  AST_STANDBY_NO_ALARM: assert property (@(posedge clk) disable iff (!rstN)
    standbyQ |=> !$rose(overTempOut)); // R3

  AST_ALARM_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overTempOut) |-> $past(|sampleValid)); // R6

  AST_ALARM_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overTempOut) |-> $past(wrEn && regAddr == OFF_STATUS && wrData[ST_CRIT])); // R10

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr < OFF_STANDBY || regAddr == 4'hF) |-> rdData == '0); // R11
endmodule

bind thermal_monitor_regs tmon_checker #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .sampleValid(sampleValid), .overTempOut(overTempOut),
  .standbyQ(standbyQ), .chanSel(chanSel)
);

// File: tb/thermal_monitor_regs_tb_top.sv
`timescale 1ns/1ps
module thermal_monitor_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [2:0]  sampleValid = '0;
  logic [23:0] sampleTemp = '0;
  logic [2:0]  sampleOpen = '0;
  logic        overTempOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  thermal_monitor_regs dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .sampleValid(sampleValid), .sampleTemp(sampleTemp),
    .sampleOpen(sampleOpen), .overTempOut(overTempOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic rdCheck(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic smp(input int ch, input logic [7:0] t, input logic op);
    @(negedge clk);
    sampleValid[ch] = 1'b1; sampleTemp[ch*8 +: 8] = t; sampleOpen[ch] = op;
    @(negedge clk);
    sampleValid = '0; sampleOpen = '0;
  endtask

  // status write and sample on the same edge
  task automatic wrWithSmp(input logic [7:0] d, input int ch, input logic [7:0] t);
    @(negedge clk);
    regAddr = 4'hA; wrData = d; wrEn = 1'b1;
    sampleValid[ch] = 1'b1; sampleTemp[ch*8 +: 8] = t; sampleOpen[ch] = 1'b0;
    @(negedge clk);
    wrEn = 1'b0; sampleValid = '0;
  endtask

  function automatic logic [7:0] expStat(int t, int lo, int hi, int cr);
    logic [7:0] s;
    s = 8'h01;
    if (t <= lo) s[1] = 1'b1;
    if (t >= hi) s[2] = 1'b1;
    if (t >= cr) s[3] = 1'b1;
    return s;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdCheck("R1 standby", 4'h8, 8'h00);
    rdCheck("R1 select", 4'h9, 8'h00);
    for (int ch = 0; ch < 3; ch++) begin
      wr(4'h9, 8'(ch));
      rdCheck("R1 status", 4'hA, 8'h00);
      rdCheck("R1 reading", 4'hB, 8'h00);
      rdCheck("R1 high", 4'hC, 8'h7F);
      rdCheck("R1 low", 4'hD, 8'h80);
      rdCheck("R1 crit", 4'hE, 8'h7F);
    end
    check("R1 alarm", {7'b0, overTempOut}, 8'h00);

    // R2 select range
    wr(4'h9, 8'h01);
    rdCheck("R2 select 1", 4'h9, 8'h01);
    wr(4'h9, 8'h03);
    rdCheck("R2 select 3 ignored", 4'h9, 8'h01);
    wr(4'h9, 8'hFF);
    rdCheck("R2 select FF ignored", 4'h9, 8'h01);

    // R12 per-channel limits
    for (int ch = 0; ch < 3; ch++) begin
      wr(4'h9, 8'(ch));
      wr(4'hC, 8'(40 + ch));
      wr(4'hD, 8'(-10 - ch));
      wr(4'hE, 8'(80 + ch));
    end
    for (int ch = 0; ch < 3; ch++) begin
      wr(4'h9, 8'(ch));
      rdCheck("R12 high", 4'hC, 8'(40 + ch));
      rdCheck("R12 low", 4'hD, 8'(-10 - ch));
      rdCheck("R12 crit", 4'hE, 8'(80 + ch));
    end

    // R11 unmapped offsets
    wr(4'h5, 8'hFF);
    wr(4'hF, 8'hFF);
    for (int a = 0; a < 8; a++) rdCheck("R11 unmapped", 4'(a), 8'h00);
    rdCheck("R11 offset F", 4'hF, 8'h00);
    wr(4'h8, 8'hFE);
    rdCheck("R11 standby upper bits", 4'h8, 8'h00);

    // R4 disabled channel ignores samples
    wr(4'h9, 8'h00);
    smp(0, 8'd100, 1'b0);
    rdCheck("R4 disabled reading", 4'hB, 8'h00);
    rdCheck("R4 disabled status", 4'hA, 8'h00);
    check("R4 disabled alarm", {7'b0, overTempOut}, 8'h00);

    // R5 R6 R10 full sweep on channel 0 (low -10, high 40, crit 80)
    wr(4'hA, 8'h01);
    for (int t = -128; t < 128; t++) begin
      wr(4'hA, 8'h0F);
      smp(0, 8'(t), 1'b0);
      rdCheck("R5 reading", 4'hB, 8'(t));
      rdCheck("R6 flags", 4'hA, expStat(t, -10, 40, 80));
      check("R10 alarm", {7'b0, overTempOut}, (t >= 80) ? 8'h01 : 8'h00);
    end

    // R6 stickiness
    wr(4'hA, 8'h0F);
    smp(0, 8'd90, 1'b0);
    smp(0, 8'd0, 1'b0);
    rdCheck("R6 sticky status", 4'hA, 8'h0D);
    rdCheck("R6 sticky reading", 4'hB, 8'h00);

    // R7 selective write-1 clear
    wr(4'hA, 8'h03);
    rdCheck("R7 clear absent low", 4'hA, 8'h0D);
    wr(4'hA, 8'h09);
    rdCheck("R7 clear crit", 4'hA, 8'h05);
    check("R10 alarm drop", {7'b0, overTempOut}, 8'h00);
    wr(4'hA, 8'h01);
    rdCheck("R7 write zero keeps", 4'hA, 8'h05);
    wr(4'hA, 8'hF5);
    rdCheck("R7 upper bits ignored", 4'hA, 8'h01);

    // R8 clear and sample collide
    smp(0, 8'd90, 1'b0);
    wrWithSmp(8'h0F, 0, 8'd95);
    rdCheck("R8 set wins", 4'hA, 8'h0D);
    check("R8 alarm held", {7'b0, overTempOut}, 8'h01);
    wrWithSmp(8'h0F, 0, 8'd0);
    rdCheck("R8 clear wins", 4'hA, 8'h01);
    check("R8 alarm cleared", {7'b0, overTempOut}, 8'h00);

    // R9 open circuit
    smp(0, 8'd100, 1'b1);
    rdCheck("R9 open status", 4'hA, 8'h41);
    rdCheck("R9 reading held", 4'hB, 8'h00);
    check("R9 no alarm", {7'b0, overTempOut}, 8'h00);
    wr(4'hA, 8'h01);
    rdCheck("R7 open bit read-only", 4'hA, 8'h41);
    smp(0, 8'd5, 1'b0);
    rdCheck("R9 open cleared", 4'hA, 8'h01);
    rdCheck("R9 reading updated", 4'hB, 8'h05);

    // R3 standby
    wr(4'h8, 8'h01);
    rdCheck("R3 standby set", 4'h8, 8'h01);
    smp(0, 8'd100, 1'b0);
    smp(0, 8'd100, 1'b1);
    rdCheck("R3 reading frozen", 4'hB, 8'h05);
    rdCheck("R3 status frozen", 4'hA, 8'h01);
    check("R3 no alarm", {7'b0, overTempOut}, 8'h00);
    wr(4'h8, 8'h00);
    smp(0, 8'd100, 1'b0);
    rdCheck("R3 resumed reading", 4'hB, 8'd100);
    rdCheck("R3 resumed status", 4'hA, 8'h0D);
    check("R10 alarm set", {7'b0, overTempOut}, 8'h01);

    // R12 bank independence with channel 2
    wr(4'h9, 8'h02);
    wr(4'hA, 8'h01);
    smp(2, 8'(-50), 1'b0);
    rdCheck("R12 ch2 status", 4'hA, 8'h03);
    rdCheck("R12 ch2 reading", 4'hB, 8'(-50));
    wr(4'h9, 8'h00);
    rdCheck("R12 ch0 untouched", 4'hA, 8'h0D);
    wr(4'hA, 8'h09);
    check("R10 alarm off", {7'b0, overTempOut}, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule